// File: doc/BRIEF.md
# Egress Port Mask Engine

This block decides where one received Ethernet frame goes on a nine-port switch. Each request carries the result of an address lookup: the port the frame arrived on, its VLAN index, whether the destination was found and its stored port mask, a locked mark on that entry, a multicast flag, and whether the source was found or has moved. Configuration inputs supply a member mask and a configured bit for each VLAN, flood masks for unknown unicast, unknown multicast and unknown sources, a disabled-port mask, a transmit-block mask, and mirror and uplink port numbers with a mirror enable. The block returns the final egress mask, a discard flag and one-cycle event pulses for the statistics counters.

Requests enter over a valid/ready handshake and pass two pipeline slots. The first slot classifies the frame and applies VLAN membership and the flood masks. The second removes disabled and blocked ports, applies the mirror rule and removes the source port. Each slot is a two-state machine: `SLOT_EMPTY` and `SLOT_FULL`. The transitions are *fill* (EMPTY to FULL when the upstream side offers data), *drain* (FULL to EMPTY when downstream takes the entry and nothing new arrives), *refill* (FULL stays FULL when downstream takes the entry and a new one loads in the same cycle) and *hold* (FULL stays FULL while downstream is stalled). Configuration inputs are expected to stay steady while a frame is in flight.

Top module: `fwd_mask_engine`

## Requirements
- R1: After reset `res_valid` is 0, `req_ready` is 1 and all four event outputs are 0.
- R2: Results leave in request order, one per accepted request; a request accepted at a rising edge shows `res_valid` high after the next rising edge, unless earlier results are still waiting.
- R3: While `res_valid` is 1 and `res_ready` is 0, the result outputs hold their values; `req_ready` is 1 when fewer than two frames are in flight, and otherwise follows `res_ready`.
- R4: When the destination was found and its entry is locked, the result mask equals the stored destination mask exactly, including any source port bit, and every other rule is skipped.
- R5: A non-locked frame whose VLAN has its configured bit at 0 gets mask 0 and discard, and `ev_unk_vlan` pulses at its handoff.
- R6: A non-locked frame of a configured VLAN whose source port is not a member bit of that VLAN's mask gets mask 0 and discard, with no event pulse.
- R7: When the destination is not found, the starting mask is the unknown-multicast flood mask if the multicast flag is 1, with `ev_unk_mc`, and otherwise the unknown-unicast flood mask, with `ev_unk_uc`; the two never pulse together.
- R8: When the source was not found or has moved, the mask is ANDed with the unknown-source mask; `ev_unk_src` pulses only for a source not found.
- R9: The mask is ANDed with the VLAN member mask and then cleared at every port set in the disabled mask or the transmit-block mask.
- R10: With mirroring enabled and the source port not equal to the uplink port, the uplink bit is set if the source port is the mirror port or the mask after R9 holds the mirror port bit; this takes place after the R9 removals.
- R11: For a non-locked frame the bit of the source port is 0 in the final mask.
- R12: `res_discard` is 1 exactly when the presented mask is all zeros.
- R13: Event outputs are high only in a cycle where `res_valid` and `res_ready` are both 1, once per result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup record offered |
| req_ready | output | 1 | Record accepted this cycle when valid |
| req_src | input | PW (4) | Arrival port number |
| req_vlan | input | VW (6) | VLAN index |
| req_dst_found | input | 1 | Destination found in the table |
| req_dst_mask | input | PORTS (9) | Stored destination port mask |
| req_dst_locked | input | 1 | Destination entry locked |
| req_mcast | input | 1 | Destination is a group address |
| req_src_found | input | 1 | Source found in the table |
| req_src_moved | input | 1 | Source seen on a different port |
| cfg_vlan_members | input | VLANS*PORTS (576) | Member mask of VLAN v at bits v*PORTS upward |
| cfg_vlan_valid | input | VLANS (64) | Configured bit per VLAN |
| cfg_unk_uc_mask | input | PORTS | Flood mask for unknown unicast |
| cfg_unk_mc_mask | input | PORTS | Flood mask for unknown multicast |
| cfg_unk_src_mask | input | PORTS | Mask for unknown or moved sources |
| cfg_disabled | input | PORTS | Disabled ports |
| cfg_tx_block | input | PORTS | Transmit-blocked ports |
| cfg_mirror_port | input | PW | Mirror port number |
| cfg_uplink_port | input | PW | Uplink port number |
| cfg_mirror_en | input | 1 | Mirror rule enable |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken this cycle when valid |
| res_mask | output | PORTS | Final egress mask |
| res_discard | output | 1 | Frame dropped |
| ev_unk_uc | output | 1 | Unknown unicast destination pulse |
| ev_unk_mc | output | 1 | Unknown multicast destination pulse |
| ev_unk_src | output | 1 | Unknown source pulse |
| ev_unk_vlan | output | 1 | Unconfigured VLAN pulse |

## Verification
A slot machine stuck in the wrong state shows within one cycle as `res_valid` or `req_ready` disagreeing with the count of frames in flight: a lost transition drops or duplicates a result, and a missed hold changes the result outputs under backpressure. A wrong classification registered in the first slot reaches the ports two edges later as a mask or discard mismatch, or as an event pulse at the handoff of the wrong frame. Because results are matched in order against a queue, a single skipped or repeated frame shifts every later comparison.

// File: rtl/fwd_mask_pkg.sv
package fwd_mask_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/fwd_slot_ctrl.sv
module fwd_slot_ctrl
    import fwd_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic down_ready,
    output logic up_ready,
    output logic load,
    output logic full
);

    slot_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    // fill / drain / refill / hold
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (up_valid)                 st_d = SLOT_FULL;
            SLOT_FULL:  if (down_ready && !up_valid)  st_d = SLOT_EMPTY;
            default:                                  st_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        up_ready = (st_q == SLOT_EMPTY) || down_ready;
        load     = up_valid && up_ready;
        full     = (st_q == SLOT_FULL);
    end

    // R3: a stalled entry stays in the slot
    a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        full && !down_ready |=> full);

    // R2: a loaded entry occupies the slot at the next cycle
    a_r2_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);

endmodule

// File: rtl/fwd_classify.sv
module fwd_classify #(
    parameter int PORTS = 9,
    parameter int VLANS = 64,
    parameter int PW    = 4,
    parameter int VW    = 6
) (
    input  logic [PW-1:0]          src,
    input  logic [VW-1:0]          vlan,
    input  logic                   dst_found,
    input  logic [PORTS-1:0]       dst_mask,
    input  logic                   dst_locked,
    input  logic                   mcast,
    input  logic                   src_found,
    input  logic                   src_moved,
    input  logic [VLANS*PORTS-1:0] vlan_members,
    input  logic [VLANS-1:0]       vlan_valid,
    input  logic [PORTS-1:0]       unk_uc_mask,
    input  logic [PORTS-1:0]       unk_mc_mask,
    input  logic [PORTS-1:0]       unk_src_mask,
    output logic [PORTS-1:0]       mask,
    output logic                   kill,
    output logic                   locked,
    output logic                   unk_uc,
    output logic                   unk_mc,
    output logic                   unk_src,
    output logic                   unk_vlan
);

    logic [PORTS-1:0] member;
    logic [PORTS-1:0] src_bit;
    logic [PORTS-1:0] cand;
    logic             known;

    always_comb begin
        for (int i = 0; i < PORTS; i++) src_bit[i] = (src == PW'(i));
    end

    always_comb begin
        member = vlan_members[int'(vlan)*PORTS +: PORTS];
        known  = vlan_valid[vlan];
    end

    always_comb begin
        mask     = '0;
        kill     = 1'b0;
        locked   = dst_found && dst_locked;
        unk_uc   = 1'b0;
        unk_mc   = 1'b0;
        unk_src  = 1'b0;
        unk_vlan = 1'b0;
        cand     = '0;
        if (locked) begin
            mask = dst_mask;
        end else if (!known) begin
            kill     = 1'b1;
            unk_vlan = 1'b1;
        end else if ((member & src_bit) == '0) begin
            kill = 1'b1;
        end else begin
            if (dst_found)  cand = dst_mask;
            else if (mcast) cand = unk_mc_mask;
            else            cand = unk_uc_mask;
            unk_uc = !dst_found && !mcast;
            unk_mc = !dst_found && mcast;
            if (!src_found || src_moved) cand = cand & unk_src_mask;
            unk_src = !src_found;
            mask = cand & member;
        end
    end

endmodule

// File: rtl/fwd_finish.sv
module fwd_finish #(
    parameter int PORTS = 9,
    parameter int PW    = 4
) (
    input  logic [PORTS-1:0] in_mask,
    input  logic             kill,
    input  logic             locked,
    input  logic [PW-1:0]    src,
    input  logic [PORTS-1:0] disabled,
    input  logic [PORTS-1:0] tx_block,
    input  logic [PW-1:0]    mirror_port,
    input  logic [PW-1:0]    uplink_port,
    input  logic             mirror_en,
    output logic [PORTS-1:0] out_mask
);

    logic [PORTS-1:0] src_bit, mir_bit, up_bit, pruned;
    logic             mirror_hit;

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            src_bit[i] = (src == PW'(i));
            mir_bit[i] = (mirror_port == PW'(i));
            up_bit[i]  = (uplink_port == PW'(i));
        end
    end

    always_comb begin
        pruned     = in_mask & ~disabled & ~tx_block;
        mirror_hit = mirror_en && (src != uplink_port) &&
                     ((src == mirror_port) || ((pruned & mir_bit) != '0));
        if (kill)        out_mask = '0;
        else if (locked) out_mask = in_mask;
        else             out_mask = (pruned | (mirror_hit ? up_bit : '0)) & ~src_bit;
    end

endmodule

// File: rtl/fwd_mask_engine.sv
module fwd_mask_engine #(
    parameter  int PORTS = 9,
    parameter  int VLANS = 64,
    localparam int PW    = $clog2(PORTS),
    localparam int VW    = $clog2(VLANS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [PW-1:0]          req_src,
    input  logic [VW-1:0]          req_vlan,
    input  logic                   req_dst_found,
    input  logic [PORTS-1:0]       req_dst_mask,
    input  logic                   req_dst_locked,
    input  logic                   req_mcast,
    input  logic                   req_src_found,
    input  logic                   req_src_moved,
    input  logic [VLANS*PORTS-1:0] cfg_vlan_members,
    input  logic [VLANS-1:0]       cfg_vlan_valid,
    input  logic [PORTS-1:0]       cfg_unk_uc_mask,
    input  logic [PORTS-1:0]       cfg_unk_mc_mask,
    input  logic [PORTS-1:0]       cfg_unk_src_mask,
    input  logic [PORTS-1:0]       cfg_disabled,
    input  logic [PORTS-1:0]       cfg_tx_block,
    input  logic [PW-1:0]          cfg_mirror_port,
    input  logic [PW-1:0]          cfg_uplink_port,
    input  logic                   cfg_mirror_en,
    output logic                   res_valid,
    input  logic                   res_ready,
    output logic [PORTS-1:0]       res_mask,
    output logic                   res_discard,
    output logic                   ev_unk_uc,
    output logic                   ev_unk_mc,
    output logic                   ev_unk_src,
    output logic                   ev_unk_vlan
);

    // first slot: classification
    logic             a_load, a_full, b_up_ready;
    logic [PORTS-1:0] c_mask;
    logic             c_kill, c_locked, c_uc, c_mc, c_us, c_uv;
    logic [PORTS-1:0] a_mask;
    logic             a_kill, a_locked, a_uc, a_mc, a_us, a_uv;
    logic [PW-1:0]    a_src;

    // second slot: pruning and mirroring
    logic             b_load, b_full;
    logic [PORTS-1:0] f_mask;
    logic [PORTS-1:0] b_mask;
    logic             b_discard, b_locked, b_uc, b_mc, b_us, b_uv;
    logic [PW-1:0]    b_src;
    logic [PORTS-1:0] b_src_bit;

    fwd_slot_ctrl u_slot_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (req_valid),
        .down_ready (b_up_ready),
        .up_ready   (req_ready),
        .load       (a_load),
        .full       (a_full)
    );

    fwd_slot_ctrl u_slot_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (a_full),
        .down_ready (res_ready),
        .up_ready   (b_up_ready),
        .load       (b_load),
        .full       (b_full)
    );

    fwd_classify #(.PORTS(PORTS), .VLANS(VLANS), .PW(PW), .VW(VW)) u_classify (
        .src          (req_src),
        .vlan         (req_vlan),
        .dst_found    (req_dst_found),
        .dst_mask     (req_dst_mask),
        .dst_locked   (req_dst_locked),
        .mcast        (req_mcast),
        .src_found    (req_src_found),
        .src_moved    (req_src_moved),
        .vlan_members (cfg_vlan_members),
        .vlan_valid   (cfg_vlan_valid),
        .unk_uc_mask  (cfg_unk_uc_mask),
        .unk_mc_mask  (cfg_unk_mc_mask),
        .unk_src_mask (cfg_unk_src_mask),
        .mask         (c_mask),
        .kill         (c_kill),
        .locked       (c_locked),
        .unk_uc       (c_uc),
        .unk_mc       (c_mc),
        .unk_src      (c_us),
        .unk_vlan     (c_uv)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_mask   <= '0;
            a_kill   <= 1'b0;
            a_locked <= 1'b0;
            a_uc     <= 1'b0;
            a_mc     <= 1'b0;
            a_us     <= 1'b0;
            a_uv     <= 1'b0;
            a_src    <= '0;
        end else if (a_load) begin
            a_mask   <= c_mask;
            a_kill   <= c_kill;
            a_locked <= c_locked;
            a_uc     <= c_uc;
            a_mc     <= c_mc;
            a_us     <= c_us;
            a_uv     <= c_uv;
            a_src    <= req_src;
        end
    end

    fwd_finish #(.PORTS(PORTS), .PW(PW)) u_finish (
        .in_mask     (a_mask),
        .kill        (a_kill),
        .locked      (a_locked),
        .src         (a_src),
        .disabled    (cfg_disabled),
        .tx_block    (cfg_tx_block),
        .mirror_port (cfg_mirror_port),
        .uplink_port (cfg_uplink_port),
        .mirror_en   (cfg_mirror_en),
        .out_mask    (f_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_mask    <= '0;
            b_discard <= 1'b0;
            b_locked  <= 1'b0;
            b_uc      <= 1'b0;
            b_mc      <= 1'b0;
            b_us      <= 1'b0;
            b_uv      <= 1'b0;
            b_src     <= '0;
        end else if (b_load) begin
            b_mask    <= f_mask;
            b_discard <= (f_mask == '0);
            b_locked  <= a_locked;
            b_uc      <= a_uc;
            b_mc      <= a_mc;
            b_us      <= a_us;
            b_uv      <= a_uv;
            b_src     <= a_src;
        end
    end

    always_comb begin
        for (int i = 0; i < PORTS; i++) b_src_bit[i] = (b_src == PW'(i));
    end

    logic fire;
    always_comb begin
        fire        = b_full && res_ready;
        res_valid   = b_full;
        res_mask    = b_mask;
        res_discard = b_discard;
        ev_unk_uc   = fire && b_uc;
        ev_unk_mc   = fire && b_mc;
        ev_unk_src  = fire && b_us;
        ev_unk_vlan = fire && b_uv;
    end

    // R3: result outputs hold while stalled
    a_r3_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_mask) && $stable(res_discard));

    // R12: discard flag agrees with the presented mask
    a_r12_discard_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_discard == (res_mask == '0)));

    // R11: no echo to the arrival port for non-locked frames
    a_r11_no_echo: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !b_locked |-> ((res_mask & b_src_bit) == '0));

    // R7: unicast and multicast flood events are exclusive
    a_r7_flood_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_unk_uc, ev_unk_mc}));

    // R5: an unconfigured VLAN always ends in discard
    a_r5_vlan_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unk_vlan |-> res_discard);

    // R13: events only at a handoff
    a_r13_event_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_unk_uc || ev_unk_mc || ev_unk_src || ev_unk_vlan) |-> res_valid && res_ready);

endmodule

// File: tb/fwd_mask_engine_test.sv
module fwd_mask_engine_test;

    localparam int P = 9;
    localparam int V = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic           req_valid, req_ready;
    logic [3:0]     req_src;
    logic [5:0]     req_vlan;
    logic           req_dst_found, req_dst_locked, req_mcast, req_src_found, req_src_moved;
    logic [P-1:0]   req_dst_mask;
    logic [V*P-1:0] cfg_vlan_members;
    logic [V-1:0]   cfg_vlan_valid;
    logic [P-1:0]   cfg_unk_uc_mask, cfg_unk_mc_mask, cfg_unk_src_mask, cfg_disabled, cfg_tx_block;
    logic [3:0]     cfg_mirror_port, cfg_uplink_port;
    logic           cfg_mirror_en;
    logic           res_valid, res_ready, res_discard;
    logic [P-1:0]   res_mask;
    logic           ev_unk_uc, ev_unk_mc, ev_unk_src, ev_unk_vlan;

    logic [P-1:0] mem [V];
    always_comb begin
        for (int v = 0; v < V; v++) cfg_vlan_members[v*P +: P] = mem[v];
    end

    fwd_mask_engine uut (.*);

    typedef struct {
        logic [P-1:0] mask;
        bit disc, uc, mc, us, uv;
        int n_a;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0, bad = 0, edges = 0;
    int   rr_mode = 0;
    bit   acc_p = 0, fire_p = 0;
    exp_t acc_e;
    string cur_tag = "R2";

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model();
        exp_t r;
        logic [P-1:0] c;
        int s, m, u;
        s = int'(req_src); m = int'(cfg_mirror_port); u = int'(cfg_uplink_port);
        r.mask = '0; r.uc = 0; r.mc = 0; r.us = 0; r.uv = 0; r.n_a = 0; r.tag = cur_tag;
        if (req_dst_found && req_dst_locked) begin
            r.mask = req_dst_mask;
        end else if (!cfg_vlan_valid[req_vlan]) begin
            r.uv = 1;
        end else if (!mem[req_vlan][s]) begin
            r.mask = '0;
        end else begin
            if (req_dst_found) c = req_dst_mask;
            else if (req_mcast) begin c = cfg_unk_mc_mask; r.mc = 1; end
            else begin c = cfg_unk_uc_mask; r.uc = 1; end
            if (!req_src_found || req_src_moved) c &= cfg_unk_src_mask;
            r.us = !req_src_found;
            c &= mem[req_vlan];
            c &= ~cfg_disabled;
            c &= ~cfg_tx_block;
            if (cfg_mirror_en && s != u && (s == m || c[m])) c[u] = 1'b1;
            c[s] = 1'b0;
            r.mask = c;
        end
        r.disc = (r.mask == '0);
        return r;
    endfunction

    always @(posedge clk) begin
        acc_p  <= rst_n && req_valid && req_ready;
        fire_p <= rst_n && res_valid && res_ready;
        acc_e  <= model();
    end

    task automatic tick();
        bit ev, exp_v, fire;
        res_ready = (rr_mode != 0) ? 1'($urandom % 2) : 1'b1;
        #2;
        exp_v = (q.size() > 0) && (edges >= q[0].n_a + 1);
        chk("R2", "res_valid", int'(res_valid), int'(exp_v));
        chk("R3", "req_ready", int'(req_ready), int'((q.size() < 2) || res_ready));
        fire = res_valid && res_ready && exp_v;
        if (res_valid && exp_v) begin
            chk(q[0].tag, "mask", int'(res_mask), int'(q[0].mask));
            chk("R12", "discard", int'(res_discard), int'(q[0].disc));
        end
        chk("R13", "ev_unk_uc", int'(ev_unk_uc), int'(fire && q[0].uc));
        chk("R13", "ev_unk_mc", int'(ev_unk_mc), int'(fire && q[0].mc));
        chk("R8",  "ev_unk_src", int'(ev_unk_src), int'(fire && q[0].us));
        chk("R5",  "ev_unk_vlan", int'(ev_unk_vlan), int'(fire && q[0].uv));
        ev = 0;
        @(negedge clk);
        edges++;
        if (fire_p) begin
            if (q.size() > 0) void'(q.pop_front());
            else chk("R2", "extra result", 1, 0);
        end
        if (acc_p) begin
            exp_t e;
            e = acc_e;
            e.n_a = edges;
            q.push_back(e);
        end
    endtask

    task automatic send(string tag, int src, int vlan, bit df, logic [P-1:0] dm,
                        bit dl, bit mc, bit sf, bit sm);
        cur_tag = tag;
        req_src = 4'(src); req_vlan = 6'(vlan);
        req_dst_found = df; req_dst_mask = dm; req_dst_locked = dl;
        req_mcast = mc; req_src_found = sf; req_src_moved = sm;
        req_valid = 1'b1;
        do tick(); while (!acc_p);
    endtask

    task automatic drain();
        req_valid = 1'b0;
        for (int i = 0; i < 200 && q.size() > 0; i++) tick();
        chk("R2", "drained", q.size(), 0);
        tick();
    endtask

    task automatic base_cfg();
        for (int v = 0; v < V; v++) mem[v] = 9'h1FF;
        mem[5] = 9'h00F;
        cfg_vlan_valid = {1'b0, {(V-1){1'b1}}};
        cfg_unk_uc_mask = 9'h0F0;
        cfg_unk_mc_mask = 9'h1AA;
        cfg_unk_src_mask = 9'h00F;
        cfg_disabled = '0; cfg_tx_block = '0;
        cfg_mirror_port = 4'd4; cfg_uplink_port = 4'd7; cfg_mirror_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b1;
        req_src = '0; req_vlan = '0; req_dst_found = 0; req_dst_mask = '0;
        req_dst_locked = 0; req_mcast = 0; req_src_found = 1; req_src_moved = 0;
        base_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "events", int'({ev_unk_uc, ev_unk_mc, ev_unk_src, ev_unk_vlan}), 0);
        @(negedge clk);

        send("R4",  2, 63, 1, 9'h006, 1, 0, 1, 0);
        send("R5",  2, 63, 1, 9'h006, 0, 0, 1, 0);
        send("R6",  6, 5,  1, 9'h1FF, 0, 0, 1, 0);
        send("R7",  0, 1,  0, 9'h000, 0, 0, 1, 0);
        send("R7",  1, 1,  0, 9'h000, 0, 1, 1, 0);
        send("R8",  3, 1,  1, 9'h1FF, 0, 0, 0, 0);
        send("R8",  3, 1,  1, 9'h1FF, 0, 0, 1, 1);
        send("R9",  0, 5,  1, 9'h1FF, 0, 0, 1, 0);
        send("R11", 5, 1,  1, 9'h1FF, 0, 0, 1, 0);
        send("R12", 5, 1,  1, 9'h020, 0, 0, 1, 0);
        drain();

        cfg_disabled = 9'h002; cfg_tx_block = 9'h004;
        send("R9",  0, 5,  1, 9'h1FF, 0, 0, 1, 0);
        drain();

        cfg_disabled = '0; cfg_tx_block = '0; cfg_mirror_en = 1'b1;
        send("R10", 4, 1, 1, 9'h003, 0, 0, 1, 0);
        send("R10", 0, 1, 1, 9'h010, 0, 0, 1, 0);
        send("R10", 7, 1, 1, 9'h010, 0, 0, 1, 0);
        send("R10", 0, 1, 1, 9'h003, 0, 0, 1, 0);
        drain();
        cfg_disabled = 9'h010;
        send("R10", 0, 1, 1, 9'h011, 0, 0, 1, 0);
        drain();

        rr_mode = 1;
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < V; v++) mem[v] = 9'($urandom);
            cfg_vlan_valid = {$urandom, $urandom};
            cfg_unk_uc_mask = 9'($urandom); cfg_unk_mc_mask = 9'($urandom);
            cfg_unk_src_mask = 9'($urandom); cfg_disabled = 9'($urandom) & 9'($urandom);
            cfg_tx_block = 9'($urandom) & 9'($urandom);
            cfg_mirror_port = 4'($urandom % 9); cfg_uplink_port = 4'($urandom % 9);
            cfg_mirror_en = 1'($urandom);
            for (int n = 0; n < 60; n++) begin
                send("R2", int'($urandom % 9), int'($urandom % 64), 1'($urandom), 9'($urandom),
                     ($urandom % 4) == 0, 1'($urandom), ($urandom % 3) != 0, ($urandom % 4) == 0);
                if ($urandom % 4 == 0) begin req_valid = 1'b0; tick(); end
            end
            drain();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule